// File: doc/BRIEF.md
# Ethernet Controller Register File and Initialization Sequencer

This block is the host-facing control path of a descriptor-ring Ethernet controller. The host reaches four 16-bit control/status registers through two ports. A write to the select port chooses a register. Later reads and writes at the data port then go to that register. Register 0 carries the command and status bits, with mixed access rules. Registers 1 and 2 hold the byte address of an initialization block in shared memory. Register 3 is plain storage.

When the host sets the initialization command, the block reads twelve 16-bit words from shared memory using a request/acknowledge read port. On completion it latches the controller configuration and drives it out to the receive and transmit ring engines. The configuration is the mode word, the 48-bit station address, the 64-bit multicast filter, and the two ring base addresses and ring lengths. The ring engines report status events back through a small set of pulse inputs. The block combines those events into a summary error bit, a summary interrupt bit and an interrupt output.

Top module: `eth_csr_init`

## Requirements
- R1: A write at host offset 4 stores the low two bits of the write data as the register select, and a read at offset 4 returns it zero-extended. Offset 0 accesses the selected register. Registers 1, 2 and 3 read back exactly what was last written. After reset the select is 0.
- R2: Register 0 bit map, from bit 15 down to bit 0, is: error summary, babble, collision error, missed frame, memory error, receive done, transmit done, init done, interrupt summary, interrupt enable, receiver on, transmitter on, transmit demand, stop, start, init. Writing 1 to any of bits 14..8 clears that bit. Writing 0 to those bits leaves them unchanged.
- R3: Transmit demand (bit 3), start (bit 1) and init (bit 0) can be set by a host write of 1, and a host write of 0 does not clear them. Setting start or init clears stop (bit 2).
- R4: Writing 1 to stop sets it and clears start and init, even when start and init are written as 1 in the same write. In that case no memory fetch starts.
- R5: Interrupt enable (bit 6) takes the written value on every register-0 write. After reset, register 0 reads 0x0004.
- R6: Setting init makes the block issue 12 reads on the memory port. Read k is at byte address B+2k, where B is {reg2[7:0], reg1[15:0]} sampled at the start. Each request is held with an unchanged address until it is acknowledged.
- R7: On completion the outputs take these values, with words w0..w11 in fetch order:
  - mode = w0;
  - station address = {w3,w2,w1};
  - filter = {w7,w6,w5,w4};
  - receive base = {w9[7:0],w8}, receive length = 2^w9[15:13];
  - transmit base = {w11[7:0],w10}, transmit length = 2^w11[15:13].
- R8: On completion the transmitter-on bit becomes the inverse of mode bit 1, and the receiver-on bit becomes the inverse of mode bit 0. A one-cycle ring index clear pulse is issued, init done is set and init is cleared, all in the same cycle.
- R9: The error summary bit reads as the OR of bits 14..11. The interrupt summary bit reads as the OR of bits 14, 12, 11, 10, 9 and 8. The irq output is high exactly when the interrupt summary and interrupt enable are both set. Host writes to bits 15, 7, 5 and 4 have no effect.
- R10: While memory error is set, receiver-on and transmitter-on are both 0.
- R11: While stop is set, init done reads 0.
- R12: Writing stop during a fetch aborts it. The request drops, no configuration output changes, and init done stays 0. A later init restarts the fetch at word 0.
- R13: The status input bits 5..0 set babble, collision error, missed frame, memory error, receive done and transmit done respectively. A transmit demand acknowledge pulse clears transmit demand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host byte offset: 0 data port, 4 select port |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for host_addr |
| status_set | input | 6 | Status event pulses from the ring engines |
| tx_demand_ack | input | 1 | Transmit engine consumed the demand |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 16 | Memory read data |
| cfg_mode | output | 16 | Latched mode word |
| cfg_station | output | 48 | Latched station address |
| cfg_filter | output | 64 | Latched multicast filter |
| cfg_rx_base | output | ADDR_W | Receive ring base |
| cfg_rx_len | output | 8 | Receive ring entry count |
| cfg_tx_base | output | ADDR_W | Transmit ring base |
| cfg_tx_len | output | 8 | Transmit ring entry count |
| ring_idx_clr | output | 1 | Pulse: ring engines reset their indices |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| tx_demand | output | 1 | Transmit demand pending |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked by assertions on every cycle:
- stop excludes start and init;
- stop excludes init done;
- memory error excludes both enables;
- irq implies interrupt enable;
- a pending request holds its address;
- configuration outputs change only together with the ring clear pulse.

Other behaviour can only be shown by the bench's scenarios, because it depends on what the host wrote and on memory contents. This covers the exact register 0 value after every combination of write-one-to-clear, set-only and pass-through bits, and the word-by-word address sequence. It also covers the decoded configuration for several modes and ring sizes, and recovery after an aborted fetch.

// File: rtl/eth_csr_init.sv
module eth_csr_init #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        host_addr,
  input  logic              host_wr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  input  logic [5:0]        status_set,
  input  logic              tx_demand_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata,
  output logic [15:0]       cfg_mode,
  output logic [47:0]       cfg_station,
  output logic [63:0]       cfg_filter,
  output logic [ADDR_W-1:0] cfg_rx_base,
  output logic [7:0]        cfg_rx_len,
  output logic [ADDR_W-1:0] cfg_tx_base,
  output logic [7:0]        cfg_tx_len,
  output logic              ring_idx_clr,
  output logic              rx_on,
  output logic              tx_on,
  output logic              tx_demand,
  output logic              irq
);
  localparam int NWORDS = 12;
  localparam int IDX_W  = $clog2(NWORDS);
  localparam int B_SERR = 15, B_BABL = 14, B_CERR = 13, B_MISS = 12, B_MERR = 11;
  localparam int B_RINT = 10, B_TINT = 9, B_IDON = 8, B_INTR = 7, B_INEA = 6;
  localparam int B_RXON = 5, B_TXON = 4, B_TDMD = 3, B_STOP = 2, B_STRT = 1, B_INIT = 0;

  logic [15:0] csr0_q, csr1_q, csr2_q, csr3_q, pre, csr0_d, csr0_view;
  logic [1:0]  sel_q;
  logic        busy_q, last, fetch_done, fetch_start, abort;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [15:0] stage_q [NWORDS-1];
  logic        serr, intr, wr_data, wr_sel;

  assign wr_data = host_wr && host_addr == 3'd0;
  assign wr_sel  = host_wr && host_addr == 3'd4;

  assign serr = |csr0_q[B_BABL:B_MERR];
  assign intr = csr0_q[B_BABL] | (|csr0_q[B_MISS:B_IDON]);
  assign csr0_view = csr0_q | ({15'b0, serr} << B_SERR) | ({15'b0, intr} << B_INTR);

  always_comb begin
    case (host_addr)
      3'd4: host_rdata = {14'b0, sel_q};
      3'd0: case (sel_q)
              2'd0: host_rdata = csr0_view;
              2'd1: host_rdata = csr1_q;
              2'd2: host_rdata = csr2_q;
              default: host_rdata = csr3_q;
            endcase
      default: host_rdata = 16'h0;
    endcase
  end

  always_comb begin
    pre = csr0_q;
    if (tx_demand_ack) pre[B_TDMD] = 1'b0;
    if (wr_data && sel_q == 2'd0) begin
      pre[B_BABL:B_IDON] = pre[B_BABL:B_IDON] & ~host_wdata[B_BABL:B_IDON];
      if (host_wdata[B_TDMD]) pre[B_TDMD] = 1'b1;
      if (host_wdata[B_STRT]) begin pre[B_STRT] = 1'b1; pre[B_STOP] = 1'b0; end
      if (host_wdata[B_INIT]) begin pre[B_INIT] = 1'b1; pre[B_STOP] = 1'b0; end
      if (host_wdata[B_STOP]) begin
        pre[B_STOP] = 1'b1; pre[B_STRT] = 1'b0; pre[B_INIT] = 1'b0;
      end
      pre[B_INEA] = host_wdata[B_INEA];
    end
    pre[B_BABL:B_TINT] = pre[B_BABL:B_TINT] | status_set;
  end

  assign last        = idx_q == IDX_W'(NWORDS - 1);
  assign fetch_done  = busy_q && mem_ack && last && pre[B_INIT];
  assign fetch_start = !busy_q && csr0_q[B_INIT] && pre[B_INIT];
  assign abort       = busy_q && !pre[B_INIT];

  always_comb begin
    csr0_d = pre;
    if (fetch_done) begin
      csr0_d[B_TXON] = !stage_q[0][1];
      csr0_d[B_RXON] = !stage_q[0][0];
      csr0_d[B_IDON] = 1'b1;
      csr0_d[B_INIT] = 1'b0;
    end
    if (csr0_d[B_MERR]) begin csr0_d[B_RXON] = 1'b0; csr0_d[B_TXON] = 1'b0; end
    if (csr0_d[B_STOP]) csr0_d[B_IDON] = 1'b0;
    csr0_d[B_SERR] = 1'b0;
    csr0_d[B_INTR] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr0_q <= 16'h0004;
      csr1_q <= '0;
      csr2_q <= '0;
      csr3_q <= '0;
      sel_q  <= '0;
    end else begin
      csr0_q <= csr0_d;
      if (wr_sel) sel_q <= host_wdata[1:0];
      if (wr_data && sel_q == 2'd1) csr1_q <= host_wdata;
      if (wr_data && sel_q == 2'd2) csr2_q <= host_wdata;
      if (wr_data && sel_q == 2'd3) csr3_q <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      for (int i = 0; i < NWORDS - 1; i++) stage_q[i] <= '0;
    end else if (busy_q) begin
      if (abort) busy_q <= 1'b0;
      else if (mem_ack) begin
        if (last) busy_q <= 1'b0;
        else begin
          stage_q[idx_q] <= mem_rdata;
          idx_q <= idx_q + 1'b1;
        end
      end
    end else if (fetch_start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      base_q <= ADDR_W'({csr2_q[7:0], csr1_q});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_mode     <= '0;
      cfg_station  <= '0;
      cfg_filter   <= '0;
      cfg_rx_base  <= '0;
      cfg_rx_len   <= 8'd1;
      cfg_tx_base  <= '0;
      cfg_tx_len   <= 8'd1;
      ring_idx_clr <= 1'b0;
    end else begin
      ring_idx_clr <= fetch_done;
      if (fetch_done) begin
        cfg_mode    <= stage_q[0];
        cfg_station <= {stage_q[3], stage_q[2], stage_q[1]};
        cfg_filter  <= {stage_q[7], stage_q[6], stage_q[5], stage_q[4]};
        cfg_rx_base <= ADDR_W'({stage_q[9][7:0], stage_q[8]});
        cfg_rx_len  <= 8'd1 << stage_q[9][15:13];
        cfg_tx_base <= ADDR_W'({mem_rdata[7:0], stage_q[10]});
        cfg_tx_len  <= 8'd1 << mem_rdata[15:13];
      end
    end
  end

  assign mem_req   = busy_q;
  assign mem_addr  = base_q + ADDR_W'({idx_q, 1'b0});
  assign rx_on     = csr0_q[B_RXON];
  assign tx_on     = csr0_q[B_TXON];
  assign tx_demand = csr0_q[B_TDMD];
  assign irq       = intr & csr0_q[B_INEA];

  p_sel_low_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> sel_q == $past(host_wdata[1:0]));
  p_stop_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csr0_q[B_STOP] |-> !csr0_q[B_STRT] && !csr0_q[B_INIT]);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !mem_req || $stable(mem_addr));
  p_done_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ring_idx_clr |-> csr0_q[B_IDON] && !csr0_q[B_INIT]);
  p_irq_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> csr0_q[B_INEA]);
  p_merr_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    csr0_q[B_MERR] |-> !rx_on && !tx_on);
  p_stop_idon_r11: assert property (@(posedge clk) disable iff (!rst_n)
    csr0_q[B_STOP] |-> !csr0_q[B_IDON]);
  p_cfg_only_on_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_mode) || !$stable(cfg_rx_base) |-> ring_idx_clr);
endmodule

// File: tb/tb_eth_csr_init.sv
module tb_eth_csr_init;
  logic clk = 0, rst_n = 0;
  logic [2:0] host_addr = 0;
  logic host_wr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic [5:0] status_set = 0;
  logic tx_demand_ack = 0;
  logic mem_req, mem_ack = 0;
  logic [23:0] mem_addr;
  logic [15:0] mem_rdata = 0;
  logic [15:0] cfg_mode;
  logic [47:0] cfg_station;
  logic [63:0] cfg_filter;
  logic [23:0] cfg_rx_base, cfg_tx_base;
  logic [7:0] cfg_rx_len, cfg_tx_len;
  logic ring_idx_clr, rx_on, tx_on, tx_demand, irq;

  eth_csr_init dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [15:0] img [12];
  logic [23:0] cur_base = 0;
  int gap = 0, wait_cnt = 0, rd_cnt = 0, addr_bad = 0;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 0;
    else if (mem_req && !mem_ack) begin
      if (wait_cnt >= gap) begin
        int j;
        j = int'((mem_addr - cur_base) >> 1);
        mem_ack <= 1;
        mem_rdata <= (j >= 0 && j < 12) ? img[j] : 16'hDEAD;
        if (mem_addr != cur_base + 24'(2 * rd_cnt)) addr_bad++;
        rd_cnt++;
        wait_cnt = 0;
      end else wait_cnt++;
    end else mem_ack <= 0;
  end

  task automatic hw(input [2:0] a, input [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input [1:0] s, output [15:0] v);
    hw(3'd4, {14'b0, s});
    host_addr = 0; #1 v = host_rdata;
  endtask

  function automatic [15:0] mwrite(input [15:0] m, input [15:0] w);
    m[14:8] = m[14:8] & ~w[14:8];
    if (w[3]) m[3] = 1;
    if (w[1]) begin m[1] = 1; m[2] = 0; end
    if (w[0]) begin m[0] = 1; m[2] = 0; end
    if (w[2]) begin m[2] = 1; m[1:0] = 0; end
    m[6] = w[6];
    return m;
  endfunction

  function automatic [15:0] rules(input [15:0] m);
    if (m[11]) m[5:4] = 0;
    if (m[2]) m[8] = 0;
    return m;
  endfunction

  function automatic [15:0] view(input [15:0] m);
    m[15] = |m[14:11];
    m[7] = m[14] | (|m[12:8]);
    return m;
  endfunction

  task automatic run_init(input [23:0] base, input [15:0] mode, input [2:0] rxc,
                          input [2:0] txc, input int g, input int seed, output bit ok);
    for (int j = 0; j < 12; j++) img[j] = 16'(16'h1357 * (j + 1)) ^ 16'(seed * 16'h0F1D);
    img[0] = mode;
    img[9][15:13] = rxc;
    img[11][15:13] = txc;
    hw(3'd4, 16'd1); hw(3'd0, base[15:0]);
    hw(3'd4, 16'd2); hw(3'd0, {8'hA5, base[23:16]});
    hw(3'd4, 16'd0); hw(3'd0, 16'h0004);
    #1; cur_base = base; gap = g; wait_cnt = 0; rd_cnt = 0; addr_bad = 0;
    hw(3'd0, 16'h0001);
    ok = 0;
    for (int t = 0; t < 300 && !ok; t++) begin
      @(negedge clk); #1;
      if (ring_idx_clr) ok = 1;
    end
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, m, exp;
    bit ok;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R5 reset value, R1 reset select
    host_addr = 0; #1;
    chk("R5 reset csr0", host_rdata, 16'h0004);
    host_addr = 4; #1;
    chk("R1 reset select", host_rdata, 0);
    chk("R9 reset irq", irq, 0);
    chk("R6 reset mem_req", mem_req, 0);

    // R1 select sweep and plain storage
    for (int s = 0; s < 8; s++) begin
      hw(3'd4, 16'(16'hBEE0 | s));
      host_addr = 4; #1;
      chk("R1 select low bits", host_rdata, 16'(s & 3));
    end
    for (int s = 1; s < 4; s++) begin
      for (int k = 0; k < 4; k++) begin
        logic [15:0] d;
        d = 16'(16'h2B71 * (s * 4 + k + 1));
        hw(3'd4, 16'(s)); hw(3'd0, d);
        host_addr = 0; #1;
        chk("R1 storage readback", host_rdata, d);
      end
    end

    // R2 R3 R4 R5 R9 R11 register 0 write sweep (init bit never written)
    hw(3'd4, 16'd0);
    m = 16'h0004;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] p;
      p = 16'(i * 40503) ^ 16'(i << 7);
      p[0] = 0;
      hw(3'd0, p);
      m = rules(mwrite(m, p));
      host_addr = 0; #1;
      chk("R2/R3/R4/R5/R11 csr0 write", host_rdata, view(m));
      chk("R9 irq", irq, view(m)[7] & m[6]);
    end

    // R13 R9 R10 event sweep
    for (int e = 0; e < 64; e++) begin
      logic [15:0] w;
      w = {8'h7F, 1'b0, 1'(e & 1), 6'b0};
      hw(3'd0, w);
      m = rules(mwrite(m, w));
      @(negedge clk); status_set = 6'(e);
      @(negedge clk); status_set = 0;
      m[14:9] = m[14:9] | 6'(e);
      m = rules(m);
      host_addr = 0; #1;
      chk("R13/R9 status events", host_rdata, view(m));
      chk("R9 irq from events", irq, view(m)[7] & m[6]);
    end

    // R13 transmit demand set/ack
    hw(3'd0, 16'h0008);
    host_addr = 0; #1;
    chk("R3 tdmd set", host_rdata[3], 1);
    chk("R13 tx_demand out", tx_demand, 1);
    hw(3'd0, 16'h0000);
    host_addr = 0; #1;
    chk("R3 zero write keeps tdmd", host_rdata[3], 1);
    @(negedge clk); tx_demand_ack = 1;
    @(negedge clk); tx_demand_ack = 0; #1;
    chk("R13 tdmd ack", host_rdata[3], 0);
    hw(3'd0, 16'h7F04);
    host_addr = 0; #1;
    chk("R5 clean state", host_rdata, 16'h0004);

    // R6 R7 R8 fetch across modes, ring sizes, stall gaps
    for (int k = 0; k < 4; k++) begin
      logic [15:0] md;
      logic [2:0] rc, tc;
      logic [23:0] b;
      md = 16'(3 - k) | 16'h5A00;
      rc = 3'((k * 3 + 1) & 7);
      tc = 3'((k * 5 + 2) & 7);
      b = {8'(k * 3 + 1), 16'(16'h2000 + k * 16'h0102)};
      run_init(b, md, rc, tc, k, k + 1, ok);
      chk("R8 completion pulse", ok, 1);
      chk("R6 read count", rd_cnt, 12);
      chk("R6 address sequence", addr_bad, 0);
      chk("R7 mode", cfg_mode, img[0]);
      chk("R7 station", cfg_station, {img[3], img[2], img[1]});
      chk("R7 filter", cfg_filter, {img[7], img[6], img[5], img[4]});
      chk("R7 rx base", cfg_rx_base, {img[9][7:0], img[8]});
      chk("R7 rx len", cfg_rx_len, 8'd1 << rc);
      chk("R7 tx base", cfg_tx_base, {img[11][7:0], img[10]});
      chk("R7 tx len", cfg_tx_len, 8'd1 << tc);
      exp = 16'h0180 | (md[1] ? 16'h0 : 16'h0010) | (md[0] ? 16'h0 : 16'h0020);
      host_addr = 0; #1;
      chk("R8 csr0 after init", host_rdata, exp);
      chk("R8 rx_on", rx_on, !md[0]);
      chk("R8 tx_on", tx_on, !md[1]);
      @(negedge clk); #1;
      chk("R8 single pulse", ring_idx_clr, 0);
    end

    // R10 memory error forces enables off; R9 irq; R11 stop clears init done
    @(negedge clk); status_set = 6'b000100;
    @(negedge clk); status_set = 0; #1;
    host_addr = 0; #1;
    chk("R10 merr disables", host_rdata, 16'h8980);
    chk("R10 rx_on off", rx_on, 0);
    chk("R10 tx_on off", tx_on, 0);
    hw(3'd0, 16'h0040);
    host_addr = 0; #1;
    chk("R9 irq enabled", irq, 1);
    chk("R5 inea readback", host_rdata, 16'h89C0);
    hw(3'd0, 16'h0044);
    host_addr = 0; #1;
    chk("R11 stop clears idon", host_rdata, 16'h88C4);
    hw(3'd0, 16'h7F04);
    host_addr = 0; #1;
    chk("R2 clear all", host_rdata, 16'h0004);
    chk("R9 irq off", irq, 0);

    // R4 stop wins over start and init in one write
    hw(3'd0, 16'h0007);
    host_addr = 0; #1;
    chk("R4 stop wins", host_rdata, 16'h0004);
    begin
      int req_seen = 0;
      for (int t = 0; t < 6; t++) begin @(negedge clk); #1; if (mem_req) req_seen++; end
      chk("R4 no fetch", req_seen, 0);
    end

    // R12 abort mid-fetch, then restart
    for (int j = 0; j < 12; j++) img[j] = 16'hC0DE ^ 16'(j);
    img[0] = 16'h0002;
    hw(3'd4, 16'd1); hw(3'd0, 16'h4000);
    hw(3'd4, 16'd2); hw(3'd0, 16'h0033);
    hw(3'd4, 16'd0);
    #1; cur_base = 24'h334000; gap = 3; wait_cnt = 0; rd_cnt = 0; addr_bad = 0;
    hw(3'd0, 16'h0001);
    repeat (5) @(negedge clk);
    hw(3'd0, 16'h0004);
    begin
      int clr_seen = 0;
      for (int t = 0; t < 30; t++) begin @(negedge clk); #1; if (ring_idx_clr) clr_seen++; end
      chk("R12 no completion", clr_seen, 0);
    end
    chk("R12 req dropped", mem_req, 0);
    chk("R12 cfg unchanged", cfg_mode, 16'h5A00);
    host_addr = 0; #1;
    chk("R12 csr0 after abort", host_rdata, 16'h0004);
    #1; wait_cnt = 0; rd_cnt = 0; addr_bad = 0; gap = 1;
    hw(3'd0, 16'h0001);
    ok = 0;
    for (int t = 0; t < 300 && !ok; t++) begin @(negedge clk); #1; if (ring_idx_clr) ok = 1; end
    chk("R12 restart completes", ok, 1);
    chk("R12 restart from word 0", addr_bad, 0);
    chk("R6 restart count", rd_cnt, 12);
    chk("R7 restart mode", cfg_mode, 16'h0002);
    host_addr = 0; #1;
    chk("R8 mode 2 enables", host_rdata, 16'h01A0);

    finish_run();
  end
endmodule